// File: doc/BRIEF.md
# Big-Endian Sub-Word Load/Store Unit

This block sits between a processor's load/store port and a 32-bit word-wide memory bus plus a separate word-wide I/O port. The processor asks for a byte, halfword or word read or write at a byte address. The block picks the target and steers the data between the processor and the correct byte lanes of the bus word. Lanes follow big-endian numbering: the lowest byte offset maps to the most significant lane.

Sub-word writes go out as a full bus word. The data is replicated across the lanes and a byte-enable mask selects the lanes to change, so no read-modify-write cycle is needed. Misaligned accesses are not split. They fail, as do addresses that hit neither the RAM nor the I/O window. A failed access completes at once with a fault flag and never reaches either bus.

One address watchpoint can be armed or disarmed. A word access to the armed address raises a one-cycle halt request. Bad arm and disarm commands raise an error pulse instead.

Top module: `be_mem_access`

## Requirements
- R1: A byte read at offset k (address bits 1:0) returns bus bits [31-8k : 24-8k], zero-extended into rsp_rdata[7:0].
- R2: A halfword read at offset 0 returns bus bits 31:16, and at offset 2 returns bits 15:0, zero-extended. A halfword access with address bit 0 set faults.
- R3: A word access with either of address bits 1:0 nonzero faults.
- R4: A byte write drives exactly one mem_be bit, where mem_be[3] covers bits 31:24 (offset 0) and mem_be[0] covers bits 7:0 (offset 3). The byte is replicated on all lanes, so only the addressed byte of the RAM word changes.
- R5: A halfword write drives mem_be 4'b1100 at offset 0 and 4'b0011 at offset 2, and changes only that half.
- R6: A word access at an address from 0x80000000 up to 0x80000000+IO_BYTES-1 goes to the I/O port, never to RAM, with io_addr = (address - 0x80000000)/4. On reads, io_rdata is returned unchanged.
- R7: A byte or halfword access inside the I/O window faults. So does any access at or above RAM_BYTES that lies outside the I/O window.
- R8: A fault is reported with rsp_fault and req_ready high in the same cycle as the request, with no mem_req or io_req. Writes and faults return rsp_rdata = 0.
- R9: In the cycle after a command, wp_error pulses if wp_arm is given while armed, or if wp_disarm is given while not armed or with an address or length that differs from the armed ones.
- R10: halt_req pulses in the cycle after the handshake of a word access whose address equals the armed watchpoint address. Byte and halfword accesses, other addresses and a disarmed watchpoint give no pulse.
- R11: After reset, req_ready, rsp_fault, halt_req, wp_error, mem_req and io_req are low, and the watchpoint is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request, held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 faults |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| req_ready | output | 1 | Access completes this cycle |
| rsp_rdata | output | 32 | Read result, zero-extended |
| rsp_fault | output | 1 | Access fault, valid with req_ready |
| mem_req | output | 1 | RAM bus request |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | MAW | RAM word index |
| mem_be | output | 4 | Lane enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | RAM read word |
| mem_ack | input | 1 | RAM completes the request |
| io_req | output | 1 | I/O port request |
| io_we | output | 1 | I/O write enable |
| io_addr | output | IAW | Word index inside the I/O window |
| io_wdata | output | 32 | I/O write data |
| io_rdata | input | 32 | I/O read word |
| io_ack | input | 1 | I/O completes the request |
| wp_arm | input | 1 | Arm the watchpoint |
| wp_disarm | input | 1 | Disarm the watchpoint |
| wp_addr | input | 32 | Watchpoint address for arm or disarm |
| wp_len | input | 32 | Watchpoint length for arm or disarm |
| wp_error | output | 1 | Pulse on a rejected command |
| halt_req | output | 1 | Pulse on a watchpoint hit |

## Verification
A faulting access gets req_ready and rsp_fault in the same cycle it is raised. A good access completes in the cycle its bus acknowledge arrives, which the bench's RAM and I/O models give one cycle after the request. The driver pushes the expected fault flag and read word for each access into a queue. The monitor pops one entry per handshake, sampled on the falling edge while req_valid and req_ready are both high, so the comparison never depends on a fixed latency. halt_req and wp_error are registered one cycle behind the handshake or command edge. The driver samples them on the falling edge right after that edge. Byte and halfword writes are checked by reading the whole word back against a shadow copy kept by the bench.

// File: rtl/be_mem_pkg.sv
// Package: shared encodings for the big-endian load/store unit.
// Assumes a 32-bit data path with four byte lanes.
package be_mem_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_IO   = 2'd2
    } tgt_e;

endpackage

// File: rtl/be_addr_decode.sv
// Module: be_addr_decode
// Classifies an access by alignment and address range into RAM, I/O or fault.
// Assumes RAM starts at 0 and the I/O window base is aligned to its size.
// Only word accesses may use the I/O window.
module be_addr_decode
    import be_mem_pkg::*;
#(
    parameter int unsigned RAM_BYTES = 4096,
    parameter logic [31:0] IO_BASE   = 32'h8000_0000,
    parameter int unsigned IO_BYTES  = 32768
) (
    input  logic [31:0] addr,
    input  logic [1:0]  size,
    output tgt_e        tgt,
    output logic        fault
);
    localparam logic [32:0] RAM_END = 33'(RAM_BYTES);
    localparam logic [32:0] IO_LO   = {1'b0, IO_BASE};
    localparam logic [32:0] IO_HI   = IO_LO + 33'(IO_BYTES);

    logic misaligned;
    logic in_ram;
    logic in_io;

    // Purpose: alignment and window tests, then target selection.
    always_comb begin
        misaligned = ((size == SZ_HALF) && addr[0])
                   || ((size == SZ_WORD) && (addr[1:0] != 2'b00))
                   || (size == SZ_BAD);
        in_ram = ({1'b0, addr} < RAM_END);
        in_io  = ({1'b0, addr} >= IO_LO) && ({1'b0, addr} < IO_HI);
        tgt    = TGT_NONE;
        fault  = 1'b1;
        if (!misaligned) begin
            if (in_ram) begin
                tgt   = TGT_RAM;
                fault = 1'b0;
            end else if (in_io && (size == SZ_WORD)) begin
                tgt   = TGT_IO;
                fault = 1'b0;
            end
        end
    end

endmodule

// File: rtl/be_lane_steer.sv
// Module: be_lane_steer
// Maps processor data to and from big-endian byte lanes of a bus word.
// Offset 0 is the most significant lane. Assumes the access is aligned.
module be_lane_steer
    import be_mem_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic [1:0]      size,
    input  logic [1:0]      off,
    input  logic [DW-1:0]   wdata,
    input  logic [DW-1:0]   bus_rdata,
    output logic [DW/8-1:0] be,
    output logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   rd_data
);
    localparam int unsigned LANES = DW / 8;
    localparam int unsigned HW    = DW / 2;

    logic [7:0] lane_b [LANES];
    logic [1:0] sel;

    // One extracted byte per bus lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_b[g] = bus_rdata[8*g +: 8];
    end

    // Purpose: lane enables, replicated write data and read extraction.
    always_comb begin
        sel = 2'(LANES - 1) - off;
        unique case (size)
            SZ_BYTE: begin
                be        = LANES'(1) << sel;
                bus_wdata = {LANES{wdata[7:0]}};
                rd_data   = {{(DW-8){1'b0}}, lane_b[sel]};
            end
            SZ_HALF: begin
                be        = off[1] ? {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}}
                                   : {{(LANES/2){1'b1}}, {(LANES/2){1'b0}}};
                bus_wdata = {2{wdata[HW-1:0]}};
                rd_data   = off[1] ? {{HW{1'b0}}, bus_rdata[HW-1:0]}
                                   : {{HW{1'b0}}, bus_rdata[DW-1:HW]};
            end
            default: begin
                be        = {LANES{1'b1}};
                bus_wdata = wdata;
                rd_data   = bus_rdata;
            end
        endcase
    end

endmodule

// File: rtl/be_watchpoint.sv
// Module: be_watchpoint
// A single address watchpoint with checked arm and disarm commands.
// A hit is a completed word access at the armed address. Arm takes priority
// over disarm when both are given together.
module be_watchpoint (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm_i,
    input  logic        disarm_i,
    input  logic [31:0] cmd_addr,
    input  logic [31:0] cmd_len,
    input  logic        acc_fire,
    input  logic [31:0] acc_addr,
    output logic        halt_o,
    output logic        error_o
);
    logic        armed_q;
    logic [31:0] addr_q;
    logic [31:0] len_q;

    // Purpose: hold the armed state, flag bad commands, detect hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            addr_q  <= '0;
            len_q   <= '0;
            halt_o  <= 1'b0;
            error_o <= 1'b0;
        end else begin
            error_o <= 1'b0;
            halt_o  <= armed_q && acc_fire && (acc_addr == addr_q);
            if (arm_i) begin
                if (armed_q) begin
                    error_o <= 1'b1;
                end else begin
                    armed_q <= 1'b1;
                    addr_q  <= cmd_addr;
                    len_q   <= cmd_len;
                end
            end else if (disarm_i) begin
                if (armed_q && (cmd_addr == addr_q) && (cmd_len == len_q)) begin
                    armed_q <= 1'b0;
                end else begin
                    error_o <= 1'b1;
                end
            end
        end
    end

    // R10: a halt pulse needs an armed watchpoint in the cycle before.
    p_halt_needs_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> $past(armed_q));

    // R9: arming twice is rejected one cycle later.
    p_double_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && arm_i) |=> error_o);

endmodule

// File: rtl/be_mem_access.sv
// Module: be_mem_access (top)
// Big-endian byte/halfword/word load/store unit in front of a word RAM bus
// and a word-only I/O port, with one access watchpoint.
// Assumes the processor holds req_* steady until req_ready, and that each bus
// raises its ack for one cycle while its request is held.
module be_mem_access
    import be_mem_pkg::*;
#(
    parameter int unsigned RAM_BYTES = 4096,
    parameter logic [31:0] IO_BASE   = 32'h8000_0000,
    parameter int unsigned IO_BYTES  = 32768,
    localparam int unsigned MAW      = $clog2(RAM_BYTES / 4),
    localparam int unsigned IAW      = $clog2(IO_BYTES / 4)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [1:0]     req_size,
    input  logic [31:0]    req_addr,
    input  logic [31:0]    req_wdata,
    output logic           req_ready,
    output logic [31:0]    rsp_rdata,
    output logic           rsp_fault,
    output logic           mem_req,
    output logic           mem_we,
    output logic [MAW-1:0] mem_addr,
    output logic [3:0]     mem_be,
    output logic [31:0]    mem_wdata,
    input  logic [31:0]    mem_rdata,
    input  logic           mem_ack,
    output logic           io_req,
    output logic           io_we,
    output logic [IAW-1:0] io_addr,
    output logic [31:0]    io_wdata,
    input  logic [31:0]    io_rdata,
    input  logic           io_ack,
    input  logic           wp_arm,
    input  logic           wp_disarm,
    input  logic [31:0]    wp_addr,
    input  logic [31:0]    wp_len,
    output logic           wp_error,
    output logic           halt_req
);
    tgt_e        tgt;
    logic        dec_fault;
    logic [31:0] steer_rd;
    logic        word_fire;

    be_addr_decode #(
        .RAM_BYTES (RAM_BYTES),
        .IO_BASE   (IO_BASE),
        .IO_BYTES  (IO_BYTES)
    ) u_decode (
        .addr  (req_addr),
        .size  (req_size),
        .tgt   (tgt),
        .fault (dec_fault)
    );

    be_lane_steer #(
        .DW (32)
    ) u_steer (
        .size      (req_size),
        .off       (req_addr[1:0]),
        .wdata     (req_wdata),
        .bus_rdata (mem_rdata),
        .be        (mem_be),
        .bus_wdata (mem_wdata),
        .rd_data   (steer_rd)
    );

    // Purpose: route the request to one bus and build the response.
    always_comb begin
        mem_req   = req_valid && (tgt == TGT_RAM);
        io_req    = req_valid && (tgt == TGT_IO);
        mem_we    = req_write;
        io_we     = req_write;
        mem_addr  = req_addr[MAW+1:2];
        io_addr   = req_addr[IAW+1:2];
        io_wdata  = req_wdata;
        rsp_fault = req_valid && dec_fault;
        req_ready = rsp_fault || (mem_req && mem_ack) || (io_req && io_ack);
        if (!req_valid || dec_fault || req_write) begin
            rsp_rdata = '0;
        end else if (tgt == TGT_IO) begin
            rsp_rdata = io_rdata;
        end else begin
            rsp_rdata = steer_rd;
        end
    end

    assign word_fire = req_valid && req_ready && (req_size == SZ_WORD);

    be_watchpoint u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (wp_arm),
        .disarm_i (wp_disarm),
        .cmd_addr (wp_addr),
        .cmd_len  (wp_len),
        .acc_fire (word_fire),
        .acc_addr (req_addr),
        .halt_o   (halt_req),
        .error_o  (wp_error)
    );

    // R8: a fault completes at once and touches neither bus.
    p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (req_ready && !mem_req && !io_req));

    // R6: never both buses at once.
    p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, io_req}));

    // R7: only word accesses reach the I/O port.
    p_io_word_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        io_req |-> (req_size == 2'd2));

    // R4: a byte write enables exactly one lane.
    p_byte_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && (req_size == 2'd0)) |-> ($countones(mem_be) == 1));

    // R5: a halfword write enables one aligned lane pair.
    p_half_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && (req_size == 2'd1)) |-> ((mem_be == 4'b1100) || (mem_be == 4'b0011)));

endmodule

// File: tb/be_mem_access_bench.sv
`timescale 1ns/1ps
module be_mem_access_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic [31:0] rsp_rdata;
    logic        rsp_fault;
    logic        mem_req, mem_we;
    logic [9:0]  mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, mem_rdata;
    logic        mem_ack;
    logic        io_req, io_we;
    logic [12:0] io_addr;
    logic [31:0] io_wdata, io_rdata;
    logic        io_ack;
    logic        wp_arm = 1'b0, wp_disarm = 1'b0;
    logic [31:0] wp_addr = '0, wp_len = '0;
    logic        wp_error, halt_req;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    logic [31:0] ram    [1024];
    logic [31:0] shadow [1024];
    logic [12:0] io_last_addr;
    logic [31:0] io_last_data;

    typedef struct {
        logic        fault;
        logic [31:0] rdata;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    be_mem_access u_be_mem_access (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_ack(io_ack),
        .wp_arm(wp_arm), .wp_disarm(wp_disarm), .wp_addr(wp_addr), .wp_len(wp_len),
        .wp_error(wp_error), .halt_req(halt_req)
    );

    // RAM model: one-cycle ack, lane-masked write on the ack edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            for (int i = 0; i < 1024; i++) ram[i] <= 32'h1020_3040 + i * 32'h0101_0101;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && mem_ack && mem_we)
                for (int l = 0; l < 4; l++)
                    if (mem_be[l]) ram[mem_addr][8*l +: 8] <= mem_wdata[8*l +: 8];
        end
    end
    assign mem_rdata = ram[mem_addr];

    // I/O model: read word encodes the index, writes are captured.
    always @(posedge clk) begin
        if (!rst_n) begin
            io_ack <= 1'b0;
            io_last_addr <= '0;
            io_last_data <= '0;
        end else begin
            io_ack <= io_req && !io_ack;
            if (io_req && io_ack && io_we) begin
                io_last_addr <= io_addr;
                io_last_data <= io_wdata;
            end
        end
    end
    assign io_rdata = {16'hC0DE, 3'b000, io_addr};

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [1:0] sz, input logic [31:0] a);
        logic [31:0] w;
        w = shadow[a[11:2]];
        case (sz)
            2'd0:    return {24'h0, w[8*(3 - a[1:0]) +: 8]};
            2'd1:    return a[1] ? {16'h0, w[15:0]} : {16'h0, w[31:16]};
            default: return w;
        endcase
    endfunction

    // Driver: push expectation, hold request until ready.
    task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] d, input logic flt, input string tag);
        exp_t e;
        e.fault = flt;
        e.tag   = tag;
        if (flt || wr) e.rdata = '0;
        else if (a[31]) e.rdata = {16'hC0DE, 3'b000, a[14:2]};
        else e.rdata = exp_read(sz, a);
        exp_q.push_back(e);
        if (wr && !flt && !a[31]) begin
            case (sz)
                2'd0:    shadow[a[11:2]][8*(3 - a[1:0]) +: 8] = d[7:0];
                2'd1:    if (a[1]) shadow[a[11:2]][15:0] = d[15:0];
                         else      shadow[a[11:2]][31:16] = d[15:0];
                default: shadow[a[11:2]] = d;
            endcase
        end
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    // Monitor: compare each handshake with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && req_valid && req_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected handshake", {31'h0, rsp_fault}, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_fault == e.fault, {e.tag, " fault"}, {31'h0, rsp_fault}, {31'h0, e.fault});
                check(rsp_rdata == e.rdata, {e.tag, " rdata"}, rsp_rdata, e.rdata);
                if (e.fault)
                    check(!mem_req && !io_req, {e.tag, " R8 bus idle"}, {30'h0, mem_req, io_req}, 32'h0);
            end
        end
    end

    task automatic wp_cmd(input logic arm, input logic dis, input logic [31:0] a,
                          input logic [31:0] len, input logic exp_err, input string tag);
        @(posedge clk); #1;
        wp_arm = arm; wp_disarm = dis; wp_addr = a; wp_len = len;
        @(posedge clk); #1;
        wp_arm = 1'b0; wp_disarm = 1'b0;
        @(negedge clk);
        check(wp_error == exp_err, tag, {31'h0, wp_error}, {31'h0, exp_err});
    endtask

    task automatic halt_check(input logic exp, input string tag);
        @(negedge clk);
        check(halt_req == exp, tag, {31'h0, halt_req}, {31'h0, exp});
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected <50000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) shadow[i] = 32'h1020_3040 + i * 32'h0101_0101;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check(!req_ready && !rsp_fault && !mem_req && !io_req, "R11 reset bus/handshake",
              {28'h0, req_ready, rsp_fault, mem_req, io_req}, 32'h0);
        check(!halt_req && !wp_error, "R11 reset watch", {30'h0, halt_req, wp_error}, 32'h0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1: byte reads on every lane
        for (int k = 0; k < 4; k++) access(1'b0, 2'd0, 32'h10 + k, 0, 1'b0, "R1 byte read");
        access(1'b0, 2'd0, 32'h3FF, 0, 1'b0, "R1 byte read top");
        // R2: halfword reads and odd address fault
        access(1'b0, 2'd1, 32'h10, 0, 1'b0, "R2 half read off0");
        access(1'b0, 2'd1, 32'h12, 0, 1'b0, "R2 half read off2");
        access(1'b0, 2'd1, 32'h11, 0, 1'b1, "R2 half odd fault");
        access(1'b1, 2'd1, 32'h13, 32'hFFFF, 1'b1, "R2 half odd write fault");
        // R3: misaligned words
        access(1'b0, 2'd2, 32'h12, 0, 1'b1, "R3 word off2 fault");
        access(1'b0, 2'd2, 32'h11, 0, 1'b1, "R3 word off1 fault");
        access(1'b0, 2'd2, 32'h14, 0, 1'b0, "R3 aligned word");
        // R4: byte writes leave other lanes alone
        access(1'b1, 2'd0, 32'h21, 32'h0000_00AB, 1'b0, "R4 byte write");
        access(1'b0, 2'd2, 32'h20, 0, 1'b0, "R4 byte write readback");
        access(1'b1, 2'd0, 32'h23, 32'hFFFF_FF5C, 1'b0, "R4 byte write lane0");
        access(1'b0, 2'd2, 32'h20, 0, 1'b0, "R4 lane0 readback");
        // R5: halfword writes
        access(1'b1, 2'd1, 32'h26, 32'h1234_BEEF, 1'b0, "R5 half write off2");
        access(1'b0, 2'd2, 32'h24, 0, 1'b0, "R5 half write off2 readback");
        access(1'b1, 2'd1, 32'h28, 32'h0000_CAFE, 1'b0, "R5 half write off0");
        access(1'b0, 2'd2, 32'h28, 0, 1'b0, "R5 half write off0 readback");
        // R6: I/O window
        access(1'b0, 2'd2, 32'h8000_0010, 0, 1'b0, "R6 io read");
        access(1'b1, 2'd2, 32'h8000_7FFC, 32'h1234_5678, 1'b0, "R6 io write top");
        @(negedge clk);
        check(io_last_addr == 13'h1FFF, "R6 io write addr", {19'h0, io_last_addr}, 32'h1FFF);
        check(io_last_data == 32'h1234_5678, "R6 io write data", io_last_data, 32'h1234_5678);
        access(1'b0, 2'd2, 32'h0000_0FFC, 0, 1'b0, "R6 last ram word");
        // R7: range faults
        access(1'b0, 2'd0, 32'h8000_0010, 0, 1'b1, "R7 io byte fault");
        access(1'b0, 2'd1, 32'h8000_0010, 0, 1'b1, "R7 io half fault");
        access(1'b0, 2'd2, 32'h8000_8000, 0, 1'b1, "R7 above io fault");
        access(1'b0, 2'd2, 32'h0000_1000, 0, 1'b1, "R7 above ram fault");
        access(1'b1, 2'd0, 32'h0000_2001, 32'h77, 1'b1, "R7 byte write out of range");
        access(1'b0, 2'd2, 32'h0000_0000, 0, 1'b0, "R7 ram intact word0");
        // R8: size code 3 faults at once
        access(1'b0, 2'd3, 32'h40, 0, 1'b1, "R8 bad size fault");

        // R9 / R10: watchpoint
        wp_cmd(1'b0, 1'b1, 32'h40, 32'd4, 1'b1, "R9 disarm while idle");
        access(1'b0, 2'd2, 32'h40, 0, 1'b0, "R10 word before arm");
        halt_check(1'b0, "R10 no halt disarmed");
        wp_cmd(1'b1, 1'b0, 32'h40, 32'd4, 1'b0, "R9 first arm ok");
        wp_cmd(1'b1, 1'b0, 32'h80, 32'd4, 1'b1, "R9 second arm error");
        access(1'b0, 2'd2, 32'h40, 0, 1'b0, "R10 word hit read");
        halt_check(1'b1, "R10 halt on word hit");
        @(negedge clk);
        check(halt_req == 1'b0, "R10 halt single pulse", {31'h0, halt_req}, 32'h0);
        access(1'b0, 2'd0, 32'h40, 0, 1'b0, "R10 byte at armed addr");
        halt_check(1'b0, "R10 no halt byte");
        access(1'b0, 2'd2, 32'h44, 0, 1'b0, "R10 other word");
        halt_check(1'b0, "R10 no halt other addr");
        access(1'b1, 2'd2, 32'h40, 32'h0BAD_F00D, 1'b0, "R10 word hit write");
        halt_check(1'b1, "R10 halt on word write");
        wp_cmd(1'b0, 1'b1, 32'h40, 32'd2, 1'b1, "R9 disarm wrong len");
        wp_cmd(1'b0, 1'b1, 32'h44, 32'd4, 1'b1, "R9 disarm wrong addr");
        wp_cmd(1'b0, 1'b1, 32'h40, 32'd4, 1'b0, "R9 disarm ok");
        access(1'b0, 2'd2, 32'h40, 0, 1'b0, "R10 word after disarm");
        halt_check(1'b0, "R10 no halt after disarm");

        repeat (2) @(posedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 32'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule